// File: doc/BRIEF.md
# Offload stream command processor

This block takes command messages one byte at a time from a valid/ready byte stream that carries a start-of-message and an end-of-message marker. It keeps a small table of per-stream offload contexts, indexed by stream id. A set-up command fills an entry, and a tear-down command retires one. Downstream logic reads the table through a combinational read port. Every successful set-up produces an eight-byte acknowledgement on a separate valid/ready response stream.

Commands are packed and big-endian, with mixed field widths and no padding after the opcode. Byte 0 holds the opcode: 1 means set-up and 2 means tear-down. Bytes 1..4 hold the stream id, most significant byte first. A set-up is 153 bytes long and carries a 148-byte context: a 48-byte connection part, a 52-byte record part and a 48-byte key part. The table keeps only these fields:
- the protocol/flag nibble, from the low four bits of byte 24
- the source port, from bytes 25..26
- the destination port, from bytes 27..28
- the 32-bit TCP sequence number, from bytes 33..36
- the version nibble, from the upper half of byte 64

A tear-down is 5 bytes long. Messages with an unknown opcode or the wrong length are counted as errors and discarded.

The parser is a state machine with five states:
- IDLE waits for a byte that carries the start marker.
- ID collects the four stream id bytes.
- BODY collects set-up bytes 5..152.
- DRAIN discards bytes up to the end marker.
- RESP holds input back while the acknowledgement is sent.

The transitions are:
- IDLE→ID on a known opcode without the end marker.
- IDLE→DRAIN on an unknown opcode without the end marker.
- ID→BODY after byte 4 of a set-up.
- ID→IDLE on the end marker. This is a complete tear-down, or an error if a set-up or tear-down ends early.
- ID→DRAIN when a tear-down has no end marker on byte 4.
- BODY→RESP on a set-up that ends correctly with a stream id inside the table.
- BODY→IDLE on an early end marker, or on a set-up whose id lies outside the table.
- BODY→DRAIN when byte 152 has no end marker.
- DRAIN→IDLE on the end marker.
- RESP→IDLE once the last response byte is accepted.

Top module: `offload_cmd_proc`

## Requirements
- R1: After reset, no table entry is live, `rsp_valid` is low, `in_ready` is high and `err_count` is zero.
- R2: When a 153-byte set-up message (opcode 1) with a stream id below DEPTH is accepted in full, the entry at that id becomes live. The entry then holds these fields:
  - flags: the low nibble of byte 24
  - source port: bytes 25..26, big-endian
  - destination port: bytes 27..28, big-endian
  - sequence: bytes 33..36, big-endian
  - version: the upper nibble of byte 64
- R3: After an accepted set-up, the response stream carries eight bytes: 0x00 0x00 0x00 0x81, then the four stream id bytes, most significant first. `rsp_last` is set on the eighth byte only. The data holds steady while `rsp_ready` is low, the first byte appears in the cycle after the final command byte is accepted, and `in_ready` stays low until the last response byte is taken.
- R4: A 5-byte tear-down (opcode 2) with an id below DEPTH clears that entry's live bit and produces no response.
- R5: A set-up or tear-down whose stream id is DEPTH or above changes no entry, produces no response and does not count as an error.
- R6: A message whose first byte is not 1 or 2 is counted as one error and discarded through its end-marker byte.
- R7: A command whose end marker comes before its expected last byte, or is missing on that byte, is counted as one error. It writes nothing and produces no response. In the missing case, the remaining bytes are discarded through the end marker.
- R8: Until the final byte of a set-up is accepted, the read port keeps showing the entry's previous contents.
- R9: Bytes accepted in IDLE without the start marker are ignored: they produce no error, no response and no table change.
- R10: `err_count` rises by exactly one in the cycle after the byte that reveals an error is accepted, and never by more than one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Command byte can be accepted |
| in_data | input | 8 | Command byte |
| in_sop | input | 1 | Byte is the first of a message |
| in_eom | input | 1 | Byte is the last of a message |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Response byte accepted |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of a response |
| rd_idx | input | IDXW | Table read index |
| rd_live | output | 1 | Entry at rd_idx holds a live context |
| rd_flags | output | 4 | Protocol/flag nibble of the entry |
| rd_sport | output | 16 | Source port of the entry |
| rd_dport | output | 16 | Destination port of the entry |
| rd_seq | output | 32 | TCP sequence number of the entry |
| rd_ver | output | 4 | Version nibble of the entry |
| err_count | output | ERRW | Count of discarded bad messages |

## Verification
A byte-position counter that has slipped captures the wrong bytes. The read port shows this in the cycle after the final byte of the next set-up. It also misplaces the length check, which shows on `err_count` one cycle after the misjudged byte. A corrupted stream id register shows up in the last four response bytes, or as an entry written or cleared at the wrong index. A state stuck in RESP or DRAIN shows within one cycle as `in_ready` held low or as a missing response. The bench compares every port against its model on every clock, so each of these faults is reported in the cycle where it first becomes visible.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    // Opcodes and response code
    localparam logic [7:0] OP_SETUP = 8'h01;
    localparam logic [7:0] OP_TEAR  = 8'h02;
    localparam logic [7:0] RSP_CODE = 8'h81;

    // Byte positions inside a command (byte 0 = opcode)
    localparam int ID_LAST      = 4;
    localparam int SETUP_LAST   = 152;
    localparam int POS_FLAGS    = 24;
    localparam int POS_SPORT_HI = 25;
    localparam int POS_SPORT_LO = 26;
    localparam int POS_DPORT_HI = 27;
    localparam int POS_DPORT_LO = 28;
    localparam int POS_SEQ_LO   = 33;
    localparam int POS_SEQ_HI   = 36;
    localparam int POS_VER      = 64;

    localparam int POSW    = $clog2(SETUP_LAST + 1);
    localparam int RSP_LEN = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_BODY,
        ST_DRAIN,
        ST_RESP
    } parse_state_t;

    typedef struct packed {
        logic        live;
        logic [3:0]  flags;
        logic [15:0] sport;
        logic [15:0] dport;
        logic [31:0] seq;
        logic [3:0]  ver;
    } ctx_t;

endpackage

// File: rtl/ocp_ctx_table.sv
module ocp_ctx_table
    import ocp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            clr_en,
    input  logic [IDXW-1:0] tbl_idx,
    input  ctx_t            wr_ctx,
    input  logic [IDXW-1:0] rd_idx,
    output ctx_t            rd_ctx
);

    ctx_t [DEPTH-1:0] cells;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        ctx_t cell_q;
        logic hit;

        assign hit = (int'(tbl_idx) == g);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (wr_en && hit) begin
                cell_q <= wr_ctx;
            end else if (clr_en && hit) begin
                cell_q.live <= 1'b0;
            end
        end

        assign cells[g] = cell_q;
    end

    always_comb begin
        if (int'(rd_idx) < DEPTH) begin
            rd_ctx = cells[rd_idx];
        end else begin
            rd_ctx = '0;
        end
    end

endmodule

// File: rtl/ocp_rsp_ser.sv
module ocp_rsp_ser
    import ocp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] stream_id,
    input  logic        rsp_ready,
    output logic        rsp_valid,
    output logic [7:0]  rsp_data,
    output logic        rsp_last,
    output logic        done
);

    localparam int CNTW = $clog2(RSP_LEN);

    typedef enum logic {
        SER_IDLE,
        SER_SEND
    } ser_state_t;

    ser_state_t               ser_q;
    logic [CNTW-1:0]          cnt_q;
    logic [31:0]              id_q;
    logic [8*RSP_LEN-1:0]     word;
    logic                     at_end;

    assign word      = {24'h0, RSP_CODE, id_q};
    assign rsp_valid = (ser_q == SER_SEND);
    assign at_end    = (int'(cnt_q) == RSP_LEN - 1);
    assign rsp_last  = rsp_valid && at_end;
    assign done      = rsp_valid && rsp_ready && at_end;
    assign rsp_data  = word[8*(RSP_LEN-1-int'(cnt_q)) +: 8];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_q <= SER_IDLE;
            cnt_q <= '0;
            id_q  <= '0;
        end else begin
            unique case (ser_q)
                SER_IDLE: begin
                    if (start) begin
                        ser_q <= SER_SEND;
                        cnt_q <= '0;
                        id_q  <= stream_id;
                    end
                end
                SER_SEND: begin
                    if (rsp_ready) begin
                        if (at_end) begin
                            ser_q <= SER_IDLE;
                        end
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ser_q <= SER_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ocp_cmd_fsm.sv
module ocp_cmd_fsm
    import ocp_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ERRW  = 16,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [7:0]      in_data,
    input  logic            in_sop,
    input  logic            in_eom,
    input  logic            rsp_done,
    output logic            rsp_start,
    output logic [31:0]     rsp_id,
    output logic            wr_en,
    output logic            clr_en,
    output logic [IDXW-1:0] tbl_idx,
    output ctx_t            wr_ctx,
    output logic [ERRW-1:0] err_count
);

    parse_state_t    state_q, state_d;
    logic [POSW-1:0] pos_q;
    logic [7:0]      opc_q;
    logic [31:0]     sid_q;
    ctx_t            stage_q;
    logic [ERRW-1:0] err_q;

    logic        take;
    logic [31:0] id_now;
    logic        id_fits_now;
    logic        id_fits_q;
    logic        op_known;
    logic        at_id_end;
    logic        at_setup_end;
    logic        err_hit;

    assign in_ready     = (state_q != ST_RESP);
    assign take         = in_valid && in_ready;
    assign id_now       = {sid_q[23:0], in_data};
    assign id_fits_now  = (id_now < 32'(DEPTH));
    assign id_fits_q    = (sid_q < 32'(DEPTH));
    assign op_known     = (in_data == OP_SETUP) || (in_data == OP_TEAR);
    assign at_id_end    = (pos_q == POSW'(ID_LAST));
    assign at_setup_end = (pos_q == POSW'(SETUP_LAST));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take && in_sop) begin
                    if (!op_known) begin
                        state_d = in_eom ? ST_IDLE : ST_DRAIN;
                    end else if (!in_eom) begin
                        state_d = ST_ID;
                    end
                end
            end
            ST_ID: begin
                if (take) begin
                    if (!at_id_end) begin
                        if (in_eom) state_d = ST_IDLE;
                    end else if (opc_q == OP_TEAR) begin
                        state_d = in_eom ? ST_IDLE : ST_DRAIN;
                    end else begin
                        state_d = in_eom ? ST_IDLE : ST_BODY;
                    end
                end
            end
            ST_BODY: begin
                if (take) begin
                    if (!at_setup_end) begin
                        if (in_eom) state_d = ST_IDLE;
                    end else if (!in_eom) begin
                        state_d = ST_DRAIN;
                    end else begin
                        state_d = id_fits_q ? ST_RESP : ST_IDLE;
                    end
                end
            end
            ST_DRAIN: begin
                if (take && in_eom) state_d = ST_IDLE;
            end
            ST_RESP: begin
                if (rsp_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        wr_en     = 1'b0;
        clr_en    = 1'b0;
        rsp_start = 1'b0;
        err_hit   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (take && in_sop) err_hit = !op_known || in_eom;
            end
            ST_ID: begin
                if (take) begin
                    if (!at_id_end) begin
                        err_hit = in_eom;
                    end else if (opc_q == OP_TEAR) begin
                        if (in_eom) clr_en = id_fits_now;
                        else        err_hit = 1'b1;
                    end else begin
                        err_hit = in_eom;
                    end
                end
            end
            ST_BODY: begin
                if (take) begin
                    if (!at_setup_end) begin
                        err_hit = in_eom;
                    end else if (!in_eom) begin
                        err_hit = 1'b1;
                    end else if (id_fits_q) begin
                        wr_en     = 1'b1;
                        rsp_start = 1'b1;
                    end
                end
            end
            ST_DRAIN: ;
            ST_RESP:  ;
            default:  ;
        endcase
    end

    assign tbl_idx   = (state_q == ST_ID) ? id_now[IDXW-1:0] : sid_q[IDXW-1:0];
    assign rsp_id    = sid_q;
    assign err_count = err_q;

    always_comb begin
        wr_ctx      = stage_q;
        wr_ctx.live = 1'b1;
    end

    // Field capture and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            opc_q   <= '0;
            sid_q   <= '0;
            stage_q <= '0;
            err_q   <= '0;
        end else begin
            if (take) begin
                pos_q <= (state_q == ST_IDLE) ? POSW'(1) : pos_q + 1'b1;
                if (state_q == ST_IDLE && in_sop) opc_q <= in_data;
                if (state_q == ST_ID) sid_q <= id_now;
                if (state_q == ST_BODY) begin
                    if (pos_q == POSW'(POS_FLAGS))    stage_q.flags       <= in_data[3:0];
                    if (pos_q == POSW'(POS_SPORT_HI)) stage_q.sport[15:8] <= in_data;
                    if (pos_q == POSW'(POS_SPORT_LO)) stage_q.sport[7:0]  <= in_data;
                    if (pos_q == POSW'(POS_DPORT_HI)) stage_q.dport[15:8] <= in_data;
                    if (pos_q == POSW'(POS_DPORT_LO)) stage_q.dport[7:0]  <= in_data;
                    if (pos_q >= POSW'(POS_SEQ_LO) && pos_q <= POSW'(POS_SEQ_HI)) begin
                        stage_q.seq <= {stage_q.seq[23:0], in_data};
                    end
                    if (pos_q == POSW'(POS_VER))      stage_q.ver         <= in_data[7:4];
                end
            end
            if (err_hit) err_q <= err_q + 1'b1;
        end
    end

endmodule

// File: rtl/offload_cmd_proc.sv
module offload_cmd_proc
    import ocp_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ERRW  = 16,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [7:0]      in_data,
    input  logic            in_sop,
    input  logic            in_eom,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [7:0]      rsp_data,
    output logic            rsp_last,
    input  logic [IDXW-1:0] rd_idx,
    output logic            rd_live,
    output logic [3:0]      rd_flags,
    output logic [15:0]     rd_sport,
    output logic [15:0]     rd_dport,
    output logic [31:0]     rd_seq,
    output logic [3:0]      rd_ver,
    output logic [ERRW-1:0] err_count
);

    logic            rsp_done;
    logic            rsp_start;
    logic [31:0]     rsp_id;
    logic            wr_en;
    logic            clr_en;
    logic [IDXW-1:0] tbl_idx;
    ctx_t            wr_ctx;
    ctx_t            rd_ctx;

    ocp_cmd_fsm #(.DEPTH(DEPTH), .ERRW(ERRW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_sop    (in_sop),
        .in_eom    (in_eom),
        .rsp_done  (rsp_done),
        .rsp_start (rsp_start),
        .rsp_id    (rsp_id),
        .wr_en     (wr_en),
        .clr_en    (clr_en),
        .tbl_idx   (tbl_idx),
        .wr_ctx    (wr_ctx),
        .err_count (err_count)
    );

    ocp_ctx_table #(.DEPTH(DEPTH)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .clr_en  (clr_en),
        .tbl_idx (tbl_idx),
        .wr_ctx  (wr_ctx),
        .rd_idx  (rd_idx),
        .rd_ctx  (rd_ctx)
    );

    ocp_rsp_ser u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rsp_start),
        .stream_id (rsp_id),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_last  (rsp_last),
        .done      (rsp_done)
    );

    assign rd_live  = rd_ctx.live;
    assign rd_flags = rd_ctx.flags;
    assign rd_sport = rd_ctx.sport;
    assign rd_dport = rd_ctx.dport;
    assign rd_seq   = rd_ctx.seq;
    assign rd_ver   = rd_ctx.ver;

endmodule

// File: rtl/ocp_chk.sv
module ocp_chk #(
    parameter int ERRW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [7:0]      rsp_data,
    input logic            rsp_last,
    input logic [ERRW-1:0] err_count
);

    // R3
    rsp_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !in_ready);

    // R3
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));

    // R3
    rsp_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (rsp_data == 8'h00 && !rsp_last));

    // R3
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid);

    // R10
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1));

endmodule

bind offload_cmd_proc ocp_chk #(.ERRW(ERRW)) u_ocp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last),
    .err_count (err_count)
);

// File: tb/offload_cmd_proc_test.sv
module offload_cmd_proc_test;

    localparam int DEPTH = 8;
    localparam int IDXW  = $clog2(DEPTH);
    localparam int ERRW  = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic            in_ready;
    logic [7:0]      in_data;
    logic            in_sop;
    logic            in_eom;
    logic            rsp_valid;
    logic            rsp_ready;
    logic [7:0]      rsp_data;
    logic            rsp_last;
    logic [IDXW-1:0] rd_idx;
    logic            rd_live;
    logic [3:0]      rd_flags;
    logic [15:0]     rd_sport;
    logic [15:0]     rd_dport;
    logic [31:0]     rd_seq;
    logic [3:0]      rd_ver;
    logic [ERRW-1:0] err_count;

    always #10 clk = ~clk;

    offload_cmd_proc #(.DEPTH(DEPTH), .ERRW(ERRW)) uut (.*);

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string cur_req = "R1";
    bit    stall_mode = 1'b0;

    // Behavioural reference model
    bit          m_live  [DEPTH];
    logic [3:0]  m_flags [DEPTH];
    logic [15:0] m_sport [DEPTH];
    logic [15:0] m_dport [DEPTH];
    logic [31:0] m_seq   [DEPTH];
    logic [3:0]  m_ver   [DEPTH];
    int          m_err;
    logic [7:0]  m_q[$];
    int          m_st;
    int          m_n;
    logic [7:0]  m_opc;
    logic [31:0] m_id;
    logic [3:0]  s_flags;
    logic [15:0] s_sport, s_dport;
    logic [31:0] s_seq;
    logic [3:0]  s_ver;

    function automatic void model_byte(logic [7:0] d, bit s, bit e);
        int last;
        int ix;
        case (m_st)
            0: begin
                if (s) begin
                    m_opc = d;
                    if (d != 8'h01 && d != 8'h02) begin
                        m_err++;
                        m_st = e ? 0 : 2;
                    end else if (e) begin
                        m_err++;
                    end else begin
                        m_st = 1;
                        m_n  = 0;
                    end
                end
            end
            1: begin
                m_n++;
                if (m_n <= 4) m_id = {m_id[23:0], d};
                if (m_n == 24) s_flags = d[3:0];
                if (m_n == 25) s_sport[15:8] = d;
                if (m_n == 26) s_sport[7:0] = d;
                if (m_n == 27) s_dport[15:8] = d;
                if (m_n == 28) s_dport[7:0] = d;
                if (m_n >= 33 && m_n <= 36) s_seq = {s_seq[23:0], d};
                if (m_n == 64) s_ver = d[7:4];
                last = (m_opc == 8'h01) ? 152 : 4;
                if (m_n < last) begin
                    if (e) begin
                        m_err++;
                        m_st = 0;
                    end
                end else if (!e) begin
                    m_err++;
                    m_st = 2;
                end else begin
                    m_st = 0;
                    if (m_id < DEPTH) begin
                        ix = int'(m_id);
                        if (m_opc == 8'h02) begin
                            m_live[ix] = 1'b0;
                        end else begin
                            m_live[ix]  = 1'b1;
                            m_flags[ix] = s_flags;
                            m_sport[ix] = s_sport;
                            m_dport[ix] = s_dport;
                            m_seq[ix]   = s_seq;
                            m_ver[ix]   = s_ver;
                            m_q.push_back(8'h00);
                            m_q.push_back(8'h00);
                            m_q.push_back(8'h00);
                            m_q.push_back(8'h81);
                            m_q.push_back(m_id[31:24]);
                            m_q.push_back(m_id[23:16]);
                            m_q.push_back(m_id[15:8]);
                            m_q.push_back(m_id[7:0]);
                        end
                    end
                end
            end
            default: begin
                if (e) m_st = 0;
            end
        endcase
    endfunction

    always @(posedge clk) begin
        bit acc;
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_live[i] = 1'b0;
            m_err = 0;
            m_q.delete();
            m_st = 0;
            m_n  = 0;
        end else begin
            acc = in_valid && (m_q.size() == 0);
            if (m_q.size() > 0 && rsp_ready) void'(m_q.pop_front());
            if (acc) model_byte(in_data, in_sop, in_eom);
        end
    end

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s during %s: actual=%0h expected=%0h at cycle %0d",
                     tag, cur_req, act, exp, cyc);
        end
    endtask

    // Compare every port against the model on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            check(in_ready == (m_q.size() == 0), "R3 in_ready", in_ready, m_q.size() == 0);
            check(rsp_valid == (m_q.size() > 0), "R3 rsp_valid", rsp_valid, m_q.size() > 0);
            if (m_q.size() > 0) begin
                check(rsp_data == m_q[0], "R3 rsp_data", rsp_data, m_q[0]);
                check(rsp_last == (m_q.size() == 1), "R3 rsp_last", rsp_last, m_q.size() == 1);
            end
            check(err_count == ERRW'(m_err), "R10 err_count", err_count, m_err);
            check(rd_live == m_live[rd_idx], "R2/R4 rd_live", rd_live, m_live[rd_idx]);
            if (m_live[rd_idx]) begin
                check(rd_flags == m_flags[rd_idx], "R2 rd_flags", rd_flags, m_flags[rd_idx]);
                check(rd_sport == m_sport[rd_idx], "R2 rd_sport", rd_sport, m_sport[rd_idx]);
                check(rd_dport == m_dport[rd_idx], "R2 rd_dport", rd_dport, m_dport[rd_idx]);
                check(rd_seq   == m_seq[rd_idx],   "R2 rd_seq",   rd_seq,   m_seq[rd_idx]);
                check(rd_ver   == m_ver[rd_idx],   "R2 rd_ver",   rd_ver,   m_ver[rd_idx]);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc == 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog during %s: actual=%0d expected=<150000 cycles", cur_req, cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Read index sweep and response back-pressure
    initial begin
        rd_idx    = '0;
        rsp_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            rd_idx    = rd_idx + 1'b1;
            rsp_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
        end
    end

    logic [7:0] msg[$];

    task automatic drive_byte(logic [7:0] d, bit s, bit e);
        in_valid = 1'b1;
        in_data  = d;
        in_sop   = s;
        in_eom   = e;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eom   = 1'b0;
        if ($urandom_range(0, 3) == 0) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send_msg();
        for (int i = 0; i < msg.size(); i++) begin
            drive_byte(msg[i], i == 0, i == msg.size() - 1);
        end
    endtask

    task automatic build_setup(logic [31:0] id, logic [3:0] fl, logic [15:0] sp,
                               logic [15:0] dp, logic [31:0] sq, logic [3:0] vr);
        msg.delete();
        msg.push_back(8'h01);
        msg.push_back(id[31:24]);
        msg.push_back(id[23:16]);
        msg.push_back(id[15:8]);
        msg.push_back(id[7:0]);
        for (int i = 5; i <= 152; i++) msg.push_back(8'(i * 37 + id[7:0]));
        msg[24] = {4'hC, fl};
        msg[25] = sp[15:8];
        msg[26] = sp[7:0];
        msg[27] = dp[15:8];
        msg[28] = dp[7:0];
        msg[33] = sq[31:24];
        msg[34] = sq[23:16];
        msg[35] = sq[15:8];
        msg[36] = sq[7:0];
        msg[64] = {vr, 4'h6};
    endtask

    task automatic build_tear(logic [31:0] id);
        msg.delete();
        msg.push_back(8'h02);
        msg.push_back(id[31:24]);
        msg.push_back(id[23:16]);
        msg.push_back(id[15:8]);
        msg.push_back(id[7:0]);
    endtask

    task automatic settle();
        repeat (12) @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        in_sop   = 1'b0;
        in_eom   = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state observed for a full sweep of the read index
        repeat (DEPTH + 2) @(posedge clk);
        #1;

        // R2 / R3: set-up with full-speed response
        cur_req = "R2";
        build_setup(32'd3, 4'b1010, 16'h1F90, 16'h01BB, 32'hDEADBEEF, 4'd3);
        send_msg();
        settle();

        // R3: response under back-pressure
        cur_req = "R3";
        stall_mode = 1'b1;
        build_setup(32'd5, 4'b1111, 16'hABCD, 16'h1234, 32'h00000001, 4'd3);
        send_msg();
        build_setup(32'd0, 4'b0001, 16'h0000, 16'hFFFF, 32'hFFFFFFFF, 4'd2);
        send_msg();
        build_setup(32'd7, 4'b0110, 16'h8000, 16'h0001, 32'h80000000, 4'd15);
        send_msg();
        settle();
        stall_mode = 1'b0;

        // R8: re-setup of a live entry; old contents stay visible until the end
        cur_req = "R8";
        build_setup(32'd5, 4'b0010, 16'h5555, 16'hAAAA, 32'h12345678, 4'd1);
        send_msg();
        settle();

        // R4: tear-down of live and never-used entries
        cur_req = "R4";
        build_tear(32'd3);
        send_msg();
        build_tear(32'd6);
        send_msg();
        settle();

        // R5: ids at or beyond the table depth
        cur_req = "R5";
        build_setup(32'd8, 4'b1000, 16'h1111, 16'h2222, 32'h33333333, 4'd3);
        send_msg();
        build_setup(32'h01000002, 4'b1000, 16'h4444, 16'h5555, 32'h66666666, 4'd3);
        send_msg();
        build_tear(32'd9);
        send_msg();
        build_tear(32'h80000005);
        send_msg();
        settle();

        // R6: unknown opcodes
        cur_req = "R6";
        msg.delete();
        for (int i = 0; i < 10; i++) msg.push_back(8'(i + 1));
        msg[0] = 8'h07;
        send_msg();
        msg.delete();
        msg.push_back(8'h81);
        send_msg();
        msg.delete();
        msg.push_back(8'h00);
        msg.push_back(8'h02);
        send_msg();
        settle();

        // R7: wrong lengths
        cur_req = "R7";
        build_setup(32'd2, 4'b1011, 16'h0101, 16'h0202, 32'h03030303, 4'd3);
        while (msg.size() > 61) void'(msg.pop_back());
        send_msg();
        build_setup(32'd2, 4'b1011, 16'h0101, 16'h0202, 32'h03030303, 4'd3);
        for (int i = 0; i < 7; i++) msg.push_back(8'h55);
        send_msg();
        build_tear(32'd0);
        msg.push_back(8'h99);
        send_msg();
        build_tear(32'd0);
        while (msg.size() > 3) void'(msg.pop_back());
        send_msg();
        msg.delete();
        msg.push_back(8'h01);
        send_msg();
        build_setup(32'd1, 4'b1011, 16'h0101, 16'h0202, 32'h03030303, 4'd3);
        while (msg.size() > 5) void'(msg.pop_back());
        send_msg();
        settle();

        // R9: stray bytes in IDLE without a start marker
        cur_req = "R9";
        drive_byte(8'h01, 1'b0, 1'b0);
        drive_byte(8'h02, 1'b0, 1'b1);
        drive_byte(8'h07, 1'b0, 1'b1);
        settle();
        check(err_count == ERRW'(m_err), "R9 err unchanged", err_count, m_err);
        check(!rsp_valid, "R9 no response", rsp_valid, 0);

        // R10: a good command right after errors still works
        cur_req = "R10";
        build_setup(32'd4, 4'b1100, 16'h0BAD, 16'hF00D, 32'hCAFEF00D, 4'd3);
        send_msg();
        settle();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule